// File: doc/BRIEF.md
# Audio DMA Register Front End

This block is the register side of a three-channel audio DMA engine: one capture channel, one playback channel and one microphone channel. Software reaches it over a small I/O-style bus that carries byte, word and dword accesses. Each access has a 6-bit offset and a size code. Write data and read data are both right-aligned on the 32-bit data lines. Each channel has a bank of sixteen offsets. The bank holds the descriptor list base, the current, prefetch and last-valid list indices, a status register, a remaining-sample count and a control register. Three global locations sit above the banks: a control word, a status word and a semaphore byte.

The DMA datapaths are outside the block. They report to it through a per-channel completion pulse. The pulse carries an interrupt-on-completion flag and the sample count of the next buffer. The block advances its indices on each completion, stops the channel when the last valid buffer finishes, and merges the enabled status bits into one interrupt line. A cold-reset bit in the global control word holds off all register writes until software releases it. A self-clearing warm-reset bit pulses the codec reset, except while playback is running.

Top module: `abm_regs`

## Requirements
- R1: After reset, the global control dword at 0x2C reads 0, each channel status word (bank offset +0x6) reads 0x0001, and irq is low.
- R2: While global control bit 1 is 0, every write is dropped except a dword write to 0x2C.
- R3: A dword write to 0x2C with bit 1 clear returns all three channels to their reset values on the next cycle. It also clears the semaphore byte. The control word reads back the written value with bit 2 forced to 0.
- R4: A dword write to 0x2C with bits 1 and 2 set while the playback channel is stopped stores the value with bit 2 cleared and drives codec_warm_rst high for exactly one cycle. Channel registers are left unchanged. While playback runs, the value is stored as written and no pulse occurs.
- R5: The banks are at 0x00 (capture, channel 0), 0x10 (playback, channel 1) and 0x20 (microphone, channel 2). Byte reads return: +0x4 current index, +0x5 last-valid index, +0x6 status low byte, +0xA prefetch index, +0xB control. Word reads return: +0x6 status, +0x8 remaining count. Dword reads return: +0x0 base, and at +0x4 the value {status[15:0], last-valid[7:0], current[7:0]}. Global dword reads return 0x2C and 0x30, and a byte read returns 0x34. All other size and offset pairs read 0.
- R6: The base register ignores data bits 2:0 and reads them as 0. Writes to the current index, prefetch index and remaining count, and writes to unmapped offsets, change nothing.
- R7: Control byte: bit 0 run, bit 1 channel reset, bit 2 last-buffer interrupt enable, bit 3 completion interrupt enable. Only bits 0, 2 and 3 are stored. Setting run from 0 loads current 0 and prefetch 1 and clears status bits 0 (halted) and 1. Writing run 0 sets halted. Writing bit 1 returns the channel to its reset values.
- R8: A completion pulse on a running, non-halted channel loads the remaining count. The pulse's completion flag sets status bit 3. If current equals last-valid, the pulse sets status bits 0, 1 and 2. Otherwise current takes the prefetch value and prefetch increments modulo 2^IDX_W. A pulse on a halted or stopped channel is ignored.
- R9: A last-valid write stores the value modulo 2^IDX_W. If the channel is running and halted and the new value differs from current, the write clears status bits 0 and 1.
- R10: Writing 1 to status bits 2 or 3 clears them. Other status bits ignore writes. A set from a completion in the same cycle wins over a clear.
- R11: A channel requests an interrupt when (status bit 2 and control bit 2) or (status bit 3 and control bit 3) holds. The global status dword at 0x30 shows the requests of channels 0, 1 and 2 in bits 5, 6 and 7. irq is high while any request is present.
- R12: The byte at 0x34 is a plain read/write semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 32 | Right-aligned write data |
| bus_rdata | output | 32 | Right-aligned read data, same cycle |
| dma_done | input | 3 | Per-channel buffer completion pulse |
| dma_ioc | input | 3 | Completion flag of the finished buffer |
| dma_cnt | input | 3*CNT_W | Per-channel sample count of the next buffer |
| ch_run | output | 3 | Per-channel run bit |
| ch_halted | output | 3 | Per-channel halted status |
| codec_cold_rst_n | output | 1 | Global control bit 1 |
| codec_warm_rst | output | 1 | One-cycle warm reset pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with IDX_W = 3, which gives 8-entry descriptor lists. With lists that short, a sweep of completions passes through every index, wraps the prefetch index from 7 to 0, and reaches the halt at the last valid entry in a handful of cycles. At each step a reference model in the bench recomputes the packed index and status word from the requirement rules and compares it with the bus. The sweep also runs into halted-channel pulses, last-valid restarts and simultaneous interrupt sources on two channels.

// File: rtl/abm_pkg.sv
package abm_pkg;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_CUR  = 4'h4;
  localparam logic [3:0] OFS_LAST = 4'h5;
  localparam logic [3:0] OFS_STAT = 4'h6;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_PRE  = 4'hA;
  localparam logic [3:0] OFS_CTL  = 4'hB;

  localparam logic [5:0] A_GCTL = 6'h2C;
  localparam logic [5:0] A_GSTA = 6'h30;
  localparam logic [5:0] A_SEMA = 6'h34;

  localparam int NUM_CH = 3;

  localparam int SR_HALT = 0;
  localparam int SR_LVB  = 2;
  localparam int SR_BUF  = 3;
  localparam int CR_RUN  = 0;
  localparam int CR_RST  = 1;
  localparam int CR_LVIE = 2;
  localparam int CR_IOCE = 3;
  localparam int GC_COLD = 1;
  localparam int GC_WARM = 2;
  localparam int GS_BASE = 5;

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  cur;
    logic [7:0]  last;
    logic [15:0] stat;
    logic [15:0] cnt;
    logic [7:0]  pre;
    logic [7:0]  ctl;
  } ch_view_t;

  function automatic logic [31:0] f_pack(input ch_view_t v);
    return {v.stat, v.last, v.cur};
  endfunction

  function automatic logic f_ch_int(input logic [15:0] stat, input logic [7:0] ctl);
    return (stat[SR_LVB] & ctl[CR_LVIE]) | (stat[SR_BUF] & ctl[CR_IOCE]);
  endfunction

  function automatic logic [31:0] f_gsta(input logic [NUM_CH-1:0] req);
    logic [31:0] g;
    g = '0;
    g[GS_BASE +: NUM_CH] = req;
    return g;
  endfunction

endpackage

// File: rtl/abm_channel.sv
module abm_channel
  import abm_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_base,
  input  logic             wr_lvi,
  input  logic             wr_sr,
  input  logic             wr_cr,
  input  logic [31:0]      wdata,
  input  logic             dma_done,
  input  logic             dma_ioc,
  input  logic [CNT_W-1:0] dma_cnt,
  output ch_view_t         view,
  output logic             int_req,
  output logic             run,
  output logic             halted
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [31:0]      base_q;
  logic [IDX_W-1:0] cur_q, last_q, pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             halt_q, celv_q, lvb_q, buf_q;
  logic             run_q, lvie_q, ioce_q;

  logic [IDX_W-1:0] new_last;
  logic adv, at_last, wipe, run_start, run_stop, resume;
  logic lvb_set, buf_set, lvb_clr, buf_clr;

  assign new_last  = wdata[IDX_W-1:0];
  assign adv       = dma_done & run_q & ~halt_q;
  assign at_last   = (cur_q == last_q);
  assign wipe      = clr | (wr_cr & wdata[CR_RST]);
  assign run_start = wr_cr & ~wipe & wdata[CR_RUN] & ~run_q;
  assign run_stop  = wr_cr & ~wipe & ~wdata[CR_RUN];
  assign resume    = wr_lvi & run_q & halt_q & (cur_q != new_last);
  assign lvb_set   = adv & at_last;
  assign buf_set   = adv & dma_ioc;
  assign lvb_clr   = wr_sr & wdata[SR_LVB];
  assign buf_clr   = wr_sr & wdata[SR_BUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; cur_q <= '0; last_q <= '0; pre_q <= '0; cnt_q <= '0;
      halt_q <= 1'b1; celv_q <= 1'b0; lvb_q <= 1'b0; buf_q <= 1'b0;
      run_q <= 1'b0; lvie_q <= 1'b0; ioce_q <= 1'b0;
    end else if (wipe) begin
      base_q <= '0; cur_q <= '0; last_q <= '0; pre_q <= '0; cnt_q <= '0;
      halt_q <= 1'b1; celv_q <= 1'b0; lvb_q <= 1'b0; buf_q <= 1'b0;
      run_q <= 1'b0; lvie_q <= 1'b0; ioce_q <= 1'b0;
    end else begin
      if (wr_base) base_q <= {wdata[31:3], 3'b000};
      if (wr_lvi) last_q <= new_last;
      if (adv) begin
        cnt_q <= dma_cnt;
        if (!at_last) begin
          cur_q <= pre_q;
          pre_q <= pre_q + IDX_ONE;
        end
      end
      lvb_q <= lvb_set | (lvb_q & ~lvb_clr);
      buf_q <= buf_set | (buf_q & ~buf_clr);
      if (run_stop || lvb_set) halt_q <= 1'b1;
      else if (run_start || resume) halt_q <= 1'b0;
      if (lvb_set) celv_q <= 1'b1;
      else if (run_start || resume) celv_q <= 1'b0;
      if (run_start) begin
        cur_q <= '0;
        pre_q <= IDX_ONE;
      end
      if (wr_cr) begin
        run_q  <= wdata[CR_RUN];
        lvie_q <= wdata[CR_LVIE];
        ioce_q <= wdata[CR_IOCE];
      end
    end
  end

  always_comb begin
    view = '0;
    view.base = base_q;
    view.cur[IDX_W-1:0]  = cur_q;
    view.last[IDX_W-1:0] = last_q;
    view.pre[IDX_W-1:0]  = pre_q;
    view.cnt[CNT_W-1:0]  = cnt_q;
    view.stat[3:0] = {buf_q, lvb_q, celv_q, halt_q};
    view.ctl[3:0]  = {ioce_q, lvie_q, 1'b0, run_q};
  end

  assign int_req = f_ch_int(view.stat, view.ctl);
  assign run     = run_q;
  assign halted  = halt_q;

endmodule

// File: rtl/abm_global.sv
module abm_global
  import abm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        glob_wr,
  input  logic        sema_wr,
  input  logic [31:0] wdata,
  input  logic        out_run,
  output logic [31:0] gcnt,
  output logic [7:0]  sema,
  output logic        chan_clr,
  output logic        cold_ok,
  output logic        warm_pulse
);

  logic [31:0] gcnt_q;
  logic [7:0]  sema_q;
  logic        warm_q;
  logic [31:0] wd_nowarm;

  assign wd_nowarm = wdata & ~(32'd1 << GC_WARM);
  assign chan_clr  = glob_wr & ~wdata[GC_COLD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      sema_q <= '0;
      warm_q <= 1'b0;
    end else begin
      warm_q <= 1'b0;
      if (glob_wr) begin
        if (!wdata[GC_COLD]) begin
          gcnt_q <= wd_nowarm;
          sema_q <= '0;
        end else if (wdata[GC_WARM] && !out_run) begin
          gcnt_q <= wd_nowarm;
          warm_q <= 1'b1;
        end else begin
          gcnt_q <= wdata;
        end
      end else if (sema_wr) begin
        sema_q <= wdata[7:0];
      end
    end
  end

  assign gcnt       = gcnt_q;
  assign sema       = sema_q;
  assign cold_ok    = gcnt_q[GC_COLD];
  assign warm_pulse = warm_q;

endmodule

// File: rtl/abm_bus.sv
module abm_bus
  import abm_pkg::*;
(
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [1:0]            bus_size,
  input  logic [5:0]            bus_addr,
  input  logic                  cold_ok,
  input  ch_view_t [NUM_CH-1:0] views,
  input  logic [31:0]           gcnt,
  input  logic [31:0]           gsta,
  input  logic [7:0]            sema,
  output logic [NUM_CH-1:0]     wr_base,
  output logic [NUM_CH-1:0]     wr_lvi,
  output logic [NUM_CH-1:0]     wr_sr,
  output logic [NUM_CH-1:0]     wr_cr,
  output logic                  glob_wr,
  output logic                  sema_wr,
  output logic [31:0]           bus_rdata
);

  logic [1:0] bank;
  logic [3:0] offs;
  logic       in_bank, wen, is_b, is_w, is_d;
  ch_view_t   sel;

  assign bank    = bus_addr[5:4];
  assign offs    = bus_addr[3:0];
  assign in_bank = (bank != 2'd3) && (offs <= OFS_CTL);
  assign wen     = bus_valid & bus_write & cold_ok;
  assign is_b    = (bus_size == SZ_BYTE);
  assign is_w    = (bus_size == SZ_WORD);
  assign is_d    = (bus_size == SZ_DWORD);

  assign glob_wr = bus_valid & bus_write & is_d & (bus_addr == A_GCTL);
  assign sema_wr = wen & is_b & (bus_addr == A_SEMA);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
    logic hit;
    assign hit        = wen & in_bank & (bank == 2'(i));
    assign wr_base[i] = hit & is_d & (offs == OFS_BASE);
    assign wr_lvi[i]  = hit & is_b & (offs == OFS_LAST);
    assign wr_sr[i]   = hit & (is_b | is_w) & (offs == OFS_STAT);
    assign wr_cr[i]   = hit & is_b & (offs == OFS_CTL);
  end

  always_comb begin
    case (bank)
      2'd0:    sel = views[0];
      2'd1:    sel = views[1];
      2'd2:    sel = views[2];
      default: sel = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (in_bank) begin
        unique case (1'b1)
          is_b: case (offs)
            OFS_CUR:  bus_rdata = {24'd0, sel.cur};
            OFS_LAST: bus_rdata = {24'd0, sel.last};
            OFS_STAT: bus_rdata = {24'd0, sel.stat[7:0]};
            OFS_PRE:  bus_rdata = {24'd0, sel.pre};
            OFS_CTL:  bus_rdata = {24'd0, sel.ctl};
            default:  bus_rdata = '0;
          endcase
          is_w: case (offs)
            OFS_STAT: bus_rdata = {16'd0, sel.stat};
            OFS_CNT:  bus_rdata = {16'd0, sel.cnt};
            default:  bus_rdata = '0;
          endcase
          is_d: case (offs)
            OFS_BASE: bus_rdata = sel.base;
            OFS_CUR:  bus_rdata = f_pack(sel);
            default:  bus_rdata = '0;
          endcase
          default: bus_rdata = '0;
        endcase
      end else if (is_d && bus_addr == A_GCTL) begin
        bus_rdata = gcnt;
      end else if (is_d && bus_addr == A_GSTA) begin
        bus_rdata = gsta;
      end else if (is_b && bus_addr == A_SEMA) begin
        bus_rdata = {24'd0, sema};
      end
    end
  end

endmodule

// File: rtl/abm_regs.sv
module abm_regs
  import abm_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [1:0]              bus_size,
  input  logic [5:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [2:0]              dma_done,
  input  logic [2:0]              dma_ioc,
  input  logic [3*CNT_W-1:0]      dma_cnt,
  output logic [2:0]              ch_run,
  output logic [2:0]              ch_halted,
  output logic                    codec_cold_rst_n,
  output logic                    codec_warm_rst,
  output logic                    irq
);

  ch_view_t [NUM_CH-1:0] views;
  logic [NUM_CH-1:0] wr_base, wr_lvi, wr_sr, wr_cr, int_req;
  logic        glob_wr, sema_wr, chan_clr, cold_ok;
  logic [31:0] gcnt, gsta;
  logic [7:0]  sema;

  abm_bus u_bus (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .cold_ok(cold_ok), .views(views), .gcnt(gcnt),
    .gsta(gsta), .sema(sema), .wr_base(wr_base), .wr_lvi(wr_lvi),
    .wr_sr(wr_sr), .wr_cr(wr_cr), .glob_wr(glob_wr), .sema_wr(sema_wr),
    .bus_rdata(bus_rdata)
  );

  abm_global u_glob (
    .clk(clk), .rst_n(rst_n), .glob_wr(glob_wr), .sema_wr(sema_wr),
    .wdata(bus_wdata), .out_run(ch_run[1]), .gcnt(gcnt), .sema(sema),
    .chan_clr(chan_clr), .cold_ok(cold_ok), .warm_pulse(codec_warm_rst)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    abm_channel #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(chan_clr),
      .wr_base(wr_base[i]), .wr_lvi(wr_lvi[i]), .wr_sr(wr_sr[i]), .wr_cr(wr_cr[i]),
      .wdata(bus_wdata), .dma_done(dma_done[i]), .dma_ioc(dma_ioc[i]),
      .dma_cnt(dma_cnt[i*CNT_W +: CNT_W]), .view(views[i]),
      .int_req(int_req[i]), .run(ch_run[i]), .halted(ch_halted[i])
    );
  end

  assign gsta             = f_gsta(int_req);
  assign irq              = |int_req;
  assign codec_cold_rst_n = cold_ok;

endmodule

// File: rtl/abm_regs_chk.sv
module abm_regs_chk
  import abm_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  glob_wr,
  input logic [2:1]            wd_bits,
  input logic                  cold_ok,
  input logic                  out_run,
  input logic                  gcnt_warm,
  input logic [7:0]            sema,
  input logic                  codec_warm_rst,
  input ch_view_t [NUM_CH-1:0] views,
  input logic [7:5]            gsta_req,
  input logic                  irq
);

  a_r2_cold_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold_ok && !glob_wr) |=> $stable(views));

  a_r3_cold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_wr && !wd_bits[1]) |=> (sema == 8'd0 && !gcnt_warm && !cold_ok));

  a_r4_warm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_wr && wd_bits[1] && wd_bits[2] && !out_run) |=> (!gcnt_warm && codec_warm_rst));

  a_r4_warm_single: assert property (@(posedge clk) disable iff (!rst_n)
    codec_warm_rst |=> !codec_warm_rst);

  a_r11_irq_gsta: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (gsta_req != 3'b000));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r8_pre_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !views[i].stat[SR_HALT] |->
        views[i].pre[IDX_W-1:0] == IDX_W'(views[i].cur[IDX_W-1:0] + 1'b1));
    a_r6_base_align: assert property (@(posedge clk) disable iff (!rst_n)
      views[i].base[2:0] == 3'b000);
    a_r11_req_src: assert property (@(posedge clk) disable iff (!rst_n)
      gsta_req[GS_BASE + i] |-> (views[i].stat[SR_LVB] || views[i].stat[SR_BUF]));
  end

endmodule

bind abm_regs abm_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_wr(glob_wr), .wd_bits(bus_wdata[2:1]),
  .cold_ok(cold_ok), .out_run(ch_run[1]), .gcnt_warm(gcnt[2]), .sema(sema),
  .codec_warm_rst(codec_warm_rst), .views(views), .gsta_req(gsta[7:5]), .irq(irq)
);

// File: tb/abm_regs_tb.sv
module abm_regs_tb;

  localparam int IDX_W = 3;
  localparam int CNT_W = 16;
  localparam int NIDX  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] dma_done = '0, dma_ioc = '0;
  logic [3*CNT_W-1:0] dma_cnt = '0;
  logic [2:0] ch_run, ch_halted;
  logic codec_cold_rst_n, codec_warm_rst, irq;

  int checks = 0, fails = 0, warm_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  abm_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_done(dma_done), .dma_ioc(dma_ioc),
    .dma_cnt(dma_cnt), .ch_run(ch_run), .ch_halted(ch_halted),
    .codec_cold_rst_n(codec_cold_rst_n), .codec_warm_rst(codec_warm_rst), .irq(irq)
  );

  always @(posedge clk) if (codec_warm_rst) warm_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] sz, input logic [5:0] a,
                      input logic [31:0] exp);
    logic [31:0] d;
    rd(sz, a, d);
    chk(tag, d, exp);
  endtask

  task automatic dma(input int ch, input logic ioc, input logic [15:0] cnt);
    @(negedge clk);
    dma_done[ch] = 1'b1; dma_ioc[ch] = ioc; dma_cnt[ch*CNT_W +: CNT_W] = cnt;
    @(posedge clk);
    #1 dma_done = '0; dma_ioc = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int m_cur, m_pre, m_lvi, m_cnt;
    logic m_halt, m_celv, m_lvb;
    logic [31:0] m_sr;
    int w0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rchk("R1 gctl", 2'd2, 6'h2C, 32'h0);
    for (int c = 0; c < 3; c++) rchk("R1 status", 2'd1, 6'(c*16 + 6), 32'h1);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 writes dropped during cold reset
    wr(2'd2, 6'h00, 32'h5555_555F);
    rchk("R2 base dropped", 2'd2, 6'h00, 32'h0);
    wr(2'd0, 6'h34, 32'hAB);
    rchk("R2 sema dropped", 2'd0, 6'h34, 32'h0);

    wr(2'd2, 6'h2C, 32'h2);
    rchk("R2 gctl accepted", 2'd2, 6'h2C, 32'h2);

    // R6 base alignment on every bank
    for (int c = 0; c < 3; c++) begin
      wr(2'd2, 6'(c*16), 32'h5555_555F);
      rchk("R6 base low bits", 2'd2, 6'(c*16), 32'h5555_5558);
    end

    // R4 warm reset with playback stopped
    wr(2'd2, 6'h2C, 32'h72);
    rchk("R4 gctl write", 2'd2, 6'h2C, 32'h72);
    w0 = warm_seen;
    wr(2'd2, 6'h2C, 32'h76);
    rchk("R4 warm self clear", 2'd2, 6'h2C, 32'h72);
    chk("R4 one pulse", 32'(warm_seen - w0), 32'd1);
    rchk("R4 base kept", 2'd2, 6'h00, 32'h5555_5558);

    // R12 semaphore
    wr(2'd0, 6'h34, 32'h5A);
    rchk("R12 sema", 2'd0, 6'h34, 32'h5A);

    // R6 read-only and unmapped writes, R5 unmapped reads
    wr(2'd0, 6'h14, 32'h5);
    wr(2'd0, 6'h1A, 32'h6);
    wr(2'd1, 6'h18, 32'h1234);
    wr(2'd2, 6'h38, 32'hFFFF_FFFF);
    rchk("R6 cur ro", 2'd0, 6'h14, 32'h0);
    rchk("R6 pre ro", 2'd0, 6'h1A, 32'h0);
    rchk("R6 cnt ro", 2'd1, 6'h18, 32'h0);
    rchk("R5 unmapped dword", 2'd2, 6'h0C, 32'h0);
    rchk("R5 unmapped byte", 2'd0, 6'h07, 32'h0);
    rchk("R5 gctl by word", 2'd1, 6'h2C, 32'h0);
    rchk("R5 unmapped high", 2'd2, 6'h38, 32'h0);

    // R9 last-valid modulo, R7 run start on playback
    wr(2'd0, 6'h15, 32'h0F);
    rchk("R9 lvi modulo", 2'd0, 6'h15, 32'h7);
    wr(2'd0, 6'h1B, 32'h0D);
    rchk("R7 ctl", 2'd0, 6'h1B, 32'h0D);
    rchk("R7 start status", 2'd1, 6'h16, 32'h0);
    rchk("R7 start pre", 2'd0, 6'h1A, 32'h1);
    chk("R7 run out", {29'd0, ch_run}, 32'h2);

    // R8 completion sweep with a reference model
    m_cur = 0; m_pre = 1; m_lvi = 7; m_cnt = 0;
    m_halt = 0; m_celv = 0; m_lvb = 0;
    for (int k = 0; k < 10; k++) begin
      dma(1, 1'b0, 16'(100 + k));
      if (!m_halt) begin
        m_cnt = 100 + k;
        if (m_cur == m_lvi) begin
          m_halt = 1; m_celv = 1; m_lvb = 1;
        end else begin
          m_cur = m_pre; m_pre = (m_pre + 1) % NIDX;
        end
      end
      m_sr = {28'd0, 1'b0, m_lvb, m_celv, m_halt};
      rchk("R8 packed", 2'd2, 6'h14, {m_sr[15:0], 8'(m_lvi), 8'(m_cur)});
      rchk("R8 count", 2'd1, 6'h18, 32'(m_cnt));
      rchk("R8 pre", 2'd0, 6'h1A, 32'(m_pre));
    end
    chk("R11 irq lvb", {31'd0, irq}, 32'h1);
    rchk("R11 gsta out", 2'd2, 6'h30, 32'h40);

    // R10 W1C of last-buffer bit
    wr(2'd0, 6'h16, 32'h04);
    rchk("R10 clear lvb", 2'd1, 6'h16, 32'h3);
    chk("R10 irq low", {31'd0, irq}, 32'h0);

    // R9 restart rules
    wr(2'd0, 6'h15, 32'h7);
    rchk("R9 equal stays halted", 2'd1, 6'h16, 32'h3);
    wr(2'd0, 6'h15, 32'h3);
    rchk("R9 restart", 2'd1, 6'h16, 32'h0);
    dma(1, 1'b1, 16'd55);
    rchk("R8 wrap packed", 2'd2, 6'h14, {16'h0008, 8'd3, 8'd0});
    rchk("R8 wrap pre", 2'd0, 6'h1A, 32'h1);
    chk("R11 irq ioc", {31'd0, irq}, 32'h1);

    // R4 warm reset ignored while playback runs
    w0 = warm_seen;
    wr(2'd2, 6'h2C, 32'h6);
    rchk("R4 warm held", 2'd2, 6'h2C, 32'h6);
    chk("R4 no pulse", 32'(warm_seen - w0), 32'd0);
    wr(2'd2, 6'h2C, 32'h2);

    // R10 only writable status bits respond
    wr(2'd1, 6'h16, 32'hFFFF);
    rchk("R10 w1c word", 2'd1, 6'h16, 32'h0);

    // R7 stop and channel reset
    wr(2'd0, 6'h1B, 32'h00);
    rchk("R7 stop halts", 2'd1, 6'h16, 32'h1);
    chk("R7 run low", {29'd0, ch_run}, 32'h0);
    wr(2'd0, 6'h1B, 32'h02);
    rchk("R7 channel reset", 2'd2, 6'h14, 32'h0001_0000);
    rchk("R7 base cleared", 2'd2, 6'h10, 32'h0);

    // R11 two sources
    wr(2'd0, 6'h0B, 32'h05);
    dma(0, 1'b0, 16'd9);
    rchk("R11 gsta in", 2'd2, 6'h30, 32'h20);
    wr(2'd0, 6'h25, 32'h2);
    wr(2'd0, 6'h2B, 32'h09);
    dma(2, 1'b1, 16'd7);
    rchk("R11 gsta both", 2'd2, 6'h30, 32'hA0);
    wr(2'd0, 6'h06, 32'h04);
    rchk("R11 gsta mic", 2'd2, 6'h30, 32'h80);
    chk("R11 irq held", {31'd0, irq}, 32'h1);
    wr(2'd1, 6'h26, 32'h08);
    chk("R11 irq cleared", {31'd0, irq}, 32'h0);

    // R8 halted/stopped pulse ignored
    dma(0, 1'b1, 16'd77);
    rchk("R8 ignored halted", 2'd1, 6'h08, 32'd9);

    // R7 stored control bits
    wr(2'd0, 6'h2B, 32'h1C);
    rchk("R7 ctl mask", 2'd0, 6'h2B, 32'h0C);

    // R3 cold reset write
    wr(2'd2, 6'h20, 32'h0000_1238);
    wr(2'd0, 6'h34, 32'h77);
    wr(2'd2, 6'h2C, 32'h74);
    rchk("R3 gctl", 2'd2, 6'h2C, 32'h70);
    rchk("R3 base", 2'd2, 6'h20, 32'h0);
    rchk("R3 sema", 2'd0, 6'h34, 32'h0);
    rchk("R3 status", 2'd1, 6'h26, 32'h1);
    wr(2'd0, 6'h25, 32'h3);
    rchk("R2 dropped again", 2'd0, 6'h25, 32'h0);

    finish_run();
  end

endmodule